// File: doc/BRIEF.md
# MDIO Management Command Engine

This block is a register-driven master for the two-wire PHY management bus. Software loads a 16-bit data register and then writes a 16-bit control word. That write launches one clause-22 frame toward an external PHY. The engine derives the management clock from the system clock. It shifts out the frame MSB first. On a read it releases the data line during the turnaround and data phase, and it samples the bits the PHY returns.

A done flag, visible in the control readback, is 1 whenever the engine is idle. Software polls this flag before launching a frame and again before using the result. When a read finishes, the value the PHY returned is in the data register. A control write that arrives while a frame is in progress is dropped.

Top module: `mdio_cmd_engine`

## Requirements
- R1: After reset the control readback has bit 15 (done) at 1, the data register reads 0, mdc is low and mdio_oe is low.
- R2: A control word carries the register number in bits 4:0, the PHY address in bits 12:8 and the write flag in bit 13 (1 = write, 0 = read). The control readback returns these three fields at the same positions, bit 15 as done, and zeros elsewhere.
- R3: A control write while idle starts a frame. Done reads 0 from the next cycle until the frame has ended, and then reads 1 again.
- R4: A frame is sent MSB first as follows: PREAMBLE_BITS ones, start bits 01, opcode 10 for a read or 01 for a write, the 5-bit PHY address, the 5-bit register number, turnaround 10 on a write, then 16 data bits.
- R5: mdc is low while idle and has a period of 2*CLK_HALF_DIV system clocks during a frame. mdio_o changes only right after a falling edge of mdc.
- R6: On a read, mdio_oe drops at the first turnaround bit and stays low to the end of the frame. mdio_i is sampled on the 16 rising edges of the data phase. After done, the data register holds the sampled value, MSB first.
- R7: A write frame carries the data register value held at launch, even if software rewrites the register while the frame is running.
- R8: A control write while busy has no effect: the control fields and the frame in progress are unchanged, and no further frame is started.
- R9: A write with reg_sel = 0 loads the data register, which data_rdata shows from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 1 selects the control word, 0 the data register |
| reg_wdata | input | 16 | Write data |
| ctrl_rdata | output | 16 | Control readback: done, write flag, PHY address, register number |
| data_rdata | output | 16 | Data register readback |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Serial data out |
| mdio_oe | output | 1 | Output enable for the data pin, low means released |
| mdio_i | input | 1 | Serial data in from the pin |

## Verification
The bench builds the engine with CLK_HALF_DIV = 2 and the full 32-bit preamble. Each frame therefore takes only 256 system clocks, while every field boundary of a real frame still appears on the wire. The short divider makes several reads and writes practical in one run, including a collision of a control write with a busy engine and a data rewrite in mid-frame. With all-ones and all-zeros addresses and data of alternating edge patterns, a misplaced field or an off-by-one turnaround shows up as a wrong bit.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
   localparam int CTL_DONE_BIT = 15;
   localparam int CTL_WR_BIT   = 13;
   localparam int ADDR_BITS    = 5;
   localparam int DATA_BITS    = 16;

   typedef struct packed {
      logic                 wr;
      logic [ADDR_BITS-1:0] phy;
      logic [ADDR_BITS-1:0] regad;
   } mdio_cmd_t;
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
   parameter int HALF_DIV = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   output logic mdc,
   output logic rise_stb,
   output logic fall_stb
);
   initial assert (HALF_DIV >= 1) else $fatal(1, "HALF_DIV must be at least 1");

   logic mdc_q;
   logic tick;

   generate
      if (HALF_DIV == 1) begin : g_nodiv
         assign tick = en;
      end else begin : g_div
         localparam int CW = $clog2(HALF_DIV);
         logic [CW-1:0] cnt_q;
         assign tick = en && (cnt_q == CW'(HALF_DIV - 1));
         always_ff @(posedge clk) begin
            if (!rst_n || !en || tick) cnt_q <= '0;
            else                       cnt_q <= cnt_q + 1'b1;
         end
      end
   endgenerate

   assign rise_stb = tick && !mdc_q;
   assign fall_stb = tick && mdc_q;
   assign mdc      = mdc_q;

   always_ff @(posedge clk) begin
      if (!rst_n || !en) mdc_q <= 1'b0;
      else if (tick)     mdc_q <= ~mdc_q;
   end

   assert_rise_sets_mdc_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rise_stb |=> mdc);
   assert_fall_clears_mdc_R5: assert property (@(posedge clk) disable iff (!rst_n)
      fall_stb |=> !mdc);
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
   import mdio_pkg::*;
#(
   parameter int PRE_LEN = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  mdio_cmd_t            cmd,
   input  logic [DATA_BITS-1:0] wdata,
   input  logic                 rise_stb,
   input  logic                 fall_stb,
   input  logic                 mdio_i,
   output logic                 busy,
   output logic                 mdio_o,
   output logic                 mdio_oe,
   output logic                 done_stb,
   output logic [DATA_BITS-1:0] rdata
);
   initial assert (PRE_LEN >= 1 && PRE_LEN <= 64) else $fatal(1, "PRE_LEN out of range");

   localparam int FRAME_LEN = PRE_LEN + 32;
   localparam int TA_IDX    = PRE_LEN + 14;
   localparam int DATA_IDX  = PRE_LEN + 16;
   localparam int IW        = $clog2(FRAME_LEN);

   logic                 busy_q;
   logic                 is_rd_q;
   logic [FRAME_LEN-1:0] sh_q;
   logic [IW-1:0]        idx_q;
   logic [DATA_BITS-1:0] rx_q;
   logic                 last_bit;

   assign last_bit = (idx_q == IW'(FRAME_LEN - 1));
   assign busy     = busy_q;
   assign mdio_o   = busy_q ? sh_q[FRAME_LEN-1] : 1'b1;
   assign mdio_oe  = busy_q && !(is_rd_q && idx_q >= IW'(TA_IDX));
   assign done_stb = busy_q && fall_stb && last_bit;
   assign rdata    = rx_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         is_rd_q <= 1'b0;
         sh_q    <= '1;
         idx_q   <= '0;
         rx_q    <= '0;
      end else if (start && !busy_q) begin
         busy_q  <= 1'b1;
         is_rd_q <= !cmd.wr;
         idx_q   <= '0;
         sh_q    <= {{PRE_LEN{1'b1}}, 2'b01,
                     (cmd.wr ? 2'b01 : 2'b10),
                     cmd.phy, cmd.regad,
                     (cmd.wr ? 2'b10 : 2'b00),
                     (cmd.wr ? wdata : {DATA_BITS{1'b0}})};
      end else if (busy_q) begin
         if (rise_stb && is_rd_q && idx_q >= IW'(DATA_IDX))
            rx_q <= {rx_q[DATA_BITS-2:0], mdio_i};
         if (fall_stb) begin
            if (last_bit) begin
               busy_q <= 1'b0;
            end else begin
               idx_q <= idx_q + 1'b1;
               sh_q  <= {sh_q[FRAME_LEN-2:0], 1'b1};
            end
         end
      end
   end

   assert_mdio_only_after_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !fall_stb) |=> $stable(mdio_o));
   assert_done_ends_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
      done_stb |=> !busy);
endmodule

// File: rtl/mdio_cmd_engine.sv
module mdio_cmd_engine
   import mdio_pkg::*;
#(
   parameter int CLK_HALF_DIV  = 10,
   parameter int PREAMBLE_BITS = 32
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        reg_wr,
   input  logic        reg_sel,
   input  logic [15:0] reg_wdata,
   output logic [15:0] ctrl_rdata,
   output logic [15:0] data_rdata,
   output logic        mdc,
   output logic        mdio_o,
   output logic        mdio_oe,
   input  logic        mdio_i
);
   mdio_cmd_t            cmd_q;
   mdio_cmd_t            cmd_new;
   logic [DATA_BITS-1:0] data_q;
   logic [DATA_BITS-1:0] rx_data;
   logic                 busy;
   logic                 start;
   logic                 done_stb;
   logic                 rise_stb;
   logic                 fall_stb;

   assign start       = reg_wr && reg_sel && !busy;
   assign cmd_new.wr    = reg_wdata[CTL_WR_BIT];
   assign cmd_new.phy   = reg_wdata[12:8];
   assign cmd_new.regad = reg_wdata[4:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd_q  <= '0;
         data_q <= '0;
      end else begin
         if (start) cmd_q <= cmd_new;
         if (done_stb && !cmd_q.wr)    data_q <= rx_data;
         else if (reg_wr && !reg_sel)  data_q <= reg_wdata;
      end
   end

   assign ctrl_rdata = {!busy, 1'b0, cmd_q.wr, cmd_q.phy, 3'b000, cmd_q.regad};
   assign data_rdata = data_q;

   mdio_clkgen #(.HALF_DIV(CLK_HALF_DIV)) u_clk (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (busy),
      .mdc      (mdc),
      .rise_stb (rise_stb),
      .fall_stb (fall_stb)
   );

   mdio_frame_seq #(.PRE_LEN(PREAMBLE_BITS)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .cmd      (cmd_new),
      .wdata    (data_q),
      .rise_stb (rise_stb),
      .fall_stb (fall_stb),
      .mdio_i   (mdio_i),
      .busy     (busy),
      .mdio_o   (mdio_o),
      .mdio_oe  (mdio_oe),
      .done_stb (done_stb),
      .rdata    (rx_data)
   );

   assert_start_clears_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> !ctrl_rdata[CTL_DONE_BIT]);
   assert_busy_ctrl_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && reg_wr && reg_sel) |=> $stable(ctrl_rdata[14:0]));
   assert_release_only_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $fell(mdio_oe)) |-> !cmd_q.wr);
   assert_mdc_idle_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mdc);
endmodule

// File: tb/mdio_cmd_engine_test.sv
module mdio_cmd_engine_test;
   localparam int DIV = 2;
   localparam int PRE = 32;
   localparam int FR  = PRE + 32;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic        reg_sel = 1'b0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] ctrl_rdata, data_rdata;
   logic        mdc, mdio_o, mdio_oe;
   logic        mdio_i = 1'b0;

   int checks = 0;
   int fails = 0;
   int frames = 0;

   typedef struct packed {
      logic [FR-1:0] bits;
      logic [FR-1:0] oe;
   } frame_t;
   frame_t exp_q[$];

   logic [15:0] phy_val = '0;
   int          mon_cnt = 0;
   logic [FR-1:0] got_bits, got_oe;
   realtime     last_rise;
   bit          period_bad;

   always #5 clk = ~clk;

   mdio_cmd_engine #(.CLK_HALF_DIV(DIV), .PREAMBLE_BITS(PRE)) uut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .ctrl_rdata(ctrl_rdata), .data_rdata(data_rdata),
      .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
   );

   task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic reg_write(input logic sel, input logic [15:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   // driver: push the expected frame, then launch it
   task automatic launch(input logic wr, input logic [4:0] phy, input logic [4:0] rg,
                         input logic [15:0] wd, input logic [15:0] rv);
      frame_t f;
      f.bits = {{PRE{1'b1}}, 2'b01, (wr ? 2'b01 : 2'b10), phy, rg,
                (wr ? 2'b10 : 2'b00), (wr ? wd : rv)};
      f.oe   = wr ? {FR{1'b1}} : {{(PRE+14){1'b1}}, 18'b0};
      phy_val = rv;
      exp_q.push_back(f);
      reg_write(1'b1, {2'b00, wr, phy, 3'b000, rg});
   endtask

   task automatic wait_done();
      while (ctrl_rdata[15] !== 1'b1) @(negedge clk);
   endtask

   // monitor: collect each frame at rising mdc, compare to the scoreboard
   always @(posedge mdc) begin
      if (mon_cnt > 0 && ($realtime - last_rise) != 2.0 * DIV * 10.0) period_bad = 1'b1;
      last_rise = $realtime;
      got_bits[FR-1-mon_cnt] = mdio_o;
      got_oe[FR-1-mon_cnt]   = mdio_oe;
      mon_cnt++;
      if (mon_cnt == FR) begin
         frame_t e;
         frames++;
         mon_cnt = 0;
         if (exp_q.size() == 0) begin
            check(1'b0, "R8 unexpected frame", 64'(frames), 64'(frames - 1));
         end else begin
            e = exp_q.pop_front();
            check(got_oe == e.oe, "R6 output enable pattern", 64'(got_oe), 64'(e.oe));
            check(((got_bits ^ e.bits) & e.oe) == '0, "R4/R7 frame bits",
                  64'(got_bits), 64'(e.bits));
            check(!period_bad, "R5 mdc period", 64'(period_bad), 64'(0));
         end
         period_bad = 1'b0;
      end
   end

   // PHY model: drive read data after the falling edge
   always @(negedge mdc) begin
      #1;
      if (mon_cnt >= PRE + 16 && mon_cnt < FR) mdio_i = phy_val[15 - (mon_cnt - (PRE + 16))];
      else mdio_i = 1'b0;
   end

   initial begin
      #2_000_000;
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      period_bad = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(ctrl_rdata[15] === 1'b1, "R1 done after reset", 64'(ctrl_rdata), 64'h8000);
      check(data_rdata === 16'h0, "R1 data after reset", 64'(data_rdata), 64'h0);
      check(mdc === 1'b0 && mdio_oe === 1'b0, "R1 idle pins", {62'b0, mdc, mdio_oe}, 64'h0);

      // R9 data register load
      reg_write(1'b0, 16'hA5C3);
      check(data_rdata === 16'hA5C3, "R9 data register", 64'(data_rdata), 64'hA5C3);

      // write frame, R2 field readback, R3 done
      launch(1'b1, 5'h11, 5'h04, 16'hA5C3, 16'h0);
      check(ctrl_rdata === 16'h3104, "R2 R3 ctrl readback while busy", 64'(ctrl_rdata), 64'h3104);
      wait_done();
      check(ctrl_rdata === 16'hB104, "R3 done after write", 64'(ctrl_rdata), 64'hB104);

      // reads with edge patterns, R6
      launch(1'b0, 5'h1F, 5'h1F, 16'h0, 16'h8001);
      check(ctrl_rdata === 16'h1F1F, "R2 read ctrl fields", 64'(ctrl_rdata), 64'h1F1F);
      wait_done();
      check(data_rdata === 16'h8001, "R6 read data 8001", 64'(data_rdata), 64'h8001);

      launch(1'b0, 5'h00, 5'h00, 16'h0, 16'h7FFE);
      wait_done();
      check(data_rdata === 16'h7FFE, "R6 read data 7FFE", 64'(data_rdata), 64'h7FFE);

      // R8 control write while busy
      launch(1'b0, 5'h03, 5'h09, 16'h0, 16'h1234);
      repeat (40) @(negedge clk);
      reg_write(1'b1, 16'h3F1F);
      check(ctrl_rdata === 16'h0309, "R8 busy ctrl write ignored", 64'(ctrl_rdata), 64'h0309);
      wait_done();
      check(data_rdata === 16'h1234, "R8 original read completes", 64'(data_rdata), 64'h1234);
      repeat (20) @(negedge clk);
      check(ctrl_rdata === 16'h8309, "R8 no second frame", 64'(ctrl_rdata), 64'h8309);

      // R7 data snapshot at launch
      reg_write(1'b0, 16'hB00F);
      launch(1'b1, 5'h0A, 5'h15, 16'hB00F, 16'h0);
      repeat (30) @(negedge clk);
      reg_write(1'b0, 16'h0000);
      check(data_rdata === 16'h0000, "R9 data write during busy", 64'(data_rdata), 64'h0);
      wait_done();
      repeat (10) @(negedge clk);

      check(exp_q.size() == 0 && frames == 5, "R8 frame count", 64'(frames), 64'd5);
      check(mdc === 1'b0 && mdio_oe === 1'b0, "R5 idle after frames", {62'b0, mdc, mdio_oe}, 64'h0);

      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule